// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block moves a programmed number of items from a source region to a destination region over a single-beat request/grant bus master port. Software loads the last-item source and destination addresses and one packed control word, which holds the increment and size codes, the item count minus one, the arbitration exponent and the cycle mode. It then unmasks and enables the channel. A peripheral starts work by raising either a single-item request or a burst request. The engine copies each item with one read beat followed by one write beat.

During a burst the channel keeps the bus for at most 2^R items and then drops its request for at least one cycle, which gives other masters a chance to win arbitration. When the last item has been written, the engine marks the control word as stopped, clears its enable and pulses done. An error response on the bus also stops the channel and raises an error flag. Both events set bits in a flag register. A companion enable register selects which flag bits drive the single interrupt line.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the bus request, done pulse and interrupt are low. The status word at offset 4 reads 0x2 (channel disabled, requests masked, burst-only off). The flag word (offset 5) and the control word (offset 3) read zero.
- R2: Register offsets are: 0 global enable (bit 0), 1 source end pointer, 2 destination end pointer, 3 control word, 4 command/status, 5 flags, 6 interrupt enable. The control word reads back exactly as it was written. Its fields are: mode [2:0], arbitration exponent [6:3], count-minus-one [16:7], source size [18:17], source increment [20:19], destination size [22:21], destination increment [24:23].
- R3: Item i of n is read at source_end − ((n−1−i) << src_inc) and written at destination_end − ((n−1−i) << dst_inc). Increment code 11 holds the address at the end pointer. The bus size output carries the source size code on reads and the destination size code on writes.
- R4: A count-minus-one value of c moves c+1 items. Each item is one read beat followed by one write beat. The write data equals the data that was read.
- R5: A burst request moves at most 2^R items per bus tenure. After that the bus request drops for at least one cycle before the next tenure.
- R6: A single request moves exactly one item per tenure. Command bit 2 sets burst-only mode and bit 3 clears it. In burst-only mode, single requests start nothing.
- R7: No bus activity starts unless all of the following hold: global enable is 1, the channel is enabled (command bit 0 sets, bit 5 clears), requests are unmasked (command bit 1 clears the mask, bit 4 sets it), and the mode field is 001.
- R8: After the last write is accepted, the mode field reads 000, the channel-enable status bit reads 0, and done is high for exactly one cycle. Flag bit 0 is set in that same cycle.
- R9: An error response on any beat ends the transfer: no further beats are issued, the channel-enable bit clears, flag bit 1 sets, and no done pulse is given.
- R10: The interrupt is high exactly when some flag bit and its enable bit (offset 6, bits [1:0]) are both set. Writing a 1 to a flag bit clears that bit.
- R11: While a beat is waiting for its grant, the request, address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| per_sreq | input | 1 | Peripheral single-item request (level) |
| per_breq | input | 1 | Peripheral burst request (level) |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | Beat direction, 1 = write |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Beat accepted in this cycle |
| bus_rdata | input | DW | Read data, valid with bus_gnt |
| bus_err | input | 1 | Error response, valid with bus_gnt |
| done_pulse | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that ends the write cycle. Reads are combinational, so the bench samples them one delta after it sets the offset on a falling edge. A beat completes at the rising edge where the grant is high, and the next beat appears on the bus in the following cycle. The bus model therefore grants on falling edges and logs exactly one beat per granted falling edge, which lets it count the beats and the request tenures without ambiguity. Done, the stopped mode, the cleared enable and the done flag all become visible together, one cycle after the final write is granted. The bench first waits for the done pulse, and only then reads the registers and compares the logged beats against addresses it computes from the requirement formulas.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int REG_OFFW = 3;
    localparam int CNT_W    = 10;
    localparam int BEAT_W   = 16;

    localparam logic [REG_OFFW-1:0] OFF_GLOBAL = 3'd0;
    localparam logic [REG_OFFW-1:0] OFF_SRCEND = 3'd1;
    localparam logic [REG_OFFW-1:0] OFF_DSTEND = 3'd2;
    localparam logic [REG_OFFW-1:0] OFF_CTRL   = 3'd3;
    localparam logic [REG_OFFW-1:0] OFF_CMD    = 3'd4;
    localparam logic [REG_OFFW-1:0] OFF_FLAGS  = 3'd5;
    localparam logic [REG_OFFW-1:0] OFF_IEN    = 3'd6;

    localparam logic [2:0] MODE_STOP  = 3'b000;
    localparam logic [2:0] MODE_BASIC = 3'b001;
    localparam logic [1:0] INC_HOLD   = 2'b11;

    typedef struct packed {
        logic [6:0]       rsvd;
        logic [1:0]       dst_inc;
        logic [1:0]       dst_size;
        logic [1:0]       src_inc;
        logic [1:0]       src_size;
        logic [CNT_W-1:0] count_m1;
        logic [3:0]       arb_pow;
        logic [2:0]       mode;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW   = 32,
    parameter int CNTW = 10
) (
    input  logic [AW-1:0]   end_ptr,
    input  logic [1:0]      inc_code,
    input  logic [CNTW-1:0] items_left,
    output logic [AW-1:0]   item_addr
);
    import dma_chan_pkg::*;

    logic [AW-1:0] back_off;

    always_comb begin
        back_off = AW'(items_left) << inc_code;
        if (inc_code == INC_HOLD) begin
            item_addr = end_ptr;
        end else begin
            item_addr = end_ptr - back_off;
        end
    end

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
    parameter int AW = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [dma_chan_pkg::REG_OFFW-1:0] off,
    input  logic [31:0]                       wdata,
    output logic [31:0]                       rdata,
    input  logic                              done_evt,
    input  logic                              err_evt,
    output logic                              glob_en,
    output logic                              chan_en,
    output logic                              masked,
    output logic                              burst_only,
    output dma_chan_pkg::ctrl_word_t          ctrl,
    output logic [AW-1:0]                     src_end,
    output logic [AW-1:0]                     dst_end,
    output logic [1:0]                        flags,
    output logic                              irq
);
    import dma_chan_pkg::*;

    typedef struct packed {
        logic          glob_en;
        logic          chan_en;
        logic          masked;
        logic          burst_only;
        ctrl_word_t    ctrl;
        logic [AW-1:0] src_end;
        logic [AW-1:0] dst_end;
        logic [1:0]    flags;
        logic [1:0]    ien;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (off)
                OFF_GLOBAL: r_d.glob_en = wdata[0];
                OFF_SRCEND: r_d.src_end = wdata[AW-1:0];
                OFF_DSTEND: r_d.dst_end = wdata[AW-1:0];
                OFF_CTRL:   r_d.ctrl    = ctrl_word_t'(wdata);
                OFF_CMD: begin
                    if (wdata[0]) r_d.chan_en    = 1'b1;
                    if (wdata[1]) r_d.masked     = 1'b0;
                    if (wdata[2]) r_d.burst_only = 1'b1;
                    if (wdata[3]) r_d.burst_only = 1'b0;
                    if (wdata[4]) r_d.masked     = 1'b1;
                    if (wdata[5]) r_d.chan_en    = 1'b0;
                end
                OFF_FLAGS:  r_d.flags = r_q.flags & ~wdata[1:0];
                OFF_IEN:    r_d.ien   = wdata[1:0];
                default:    r_d = r_q;
            endcase
        end
        if (done_evt) begin
            r_d.ctrl.mode = MODE_STOP;
            r_d.chan_en   = 1'b0;
            r_d.flags[0]  = 1'b1;
        end
        if (err_evt) begin
            r_d.chan_en  = 1'b0;
            r_d.flags[1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.masked <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (off)
            OFF_GLOBAL: rdata = {31'd0, r_q.glob_en};
            OFF_SRCEND: rdata = 32'(r_q.src_end);
            OFF_DSTEND: rdata = 32'(r_q.dst_end);
            OFF_CTRL:   rdata = 32'(r_q.ctrl);
            OFF_CMD:    rdata = {29'd0, r_q.burst_only, r_q.masked, r_q.chan_en};
            OFF_FLAGS:  rdata = {30'd0, r_q.flags};
            OFF_IEN:    rdata = {30'd0, r_q.ien};
            default:    rdata = 32'd0;
        endcase
    end

    assign glob_en    = r_q.glob_en;
    assign chan_en    = r_q.chan_en;
    assign masked     = r_q.masked;
    assign burst_only = r_q.burst_only;
    assign ctrl       = r_q.ctrl;
    assign src_end    = r_q.src_end;
    assign dst_end    = r_q.dst_end;
    assign flags      = r_q.flags;
    assign irq        = |(r_q.flags & r_q.ien);

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNTW  = 10,
    parameter int BEATW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glob_en,
    input  logic            chan_en,
    input  logic            masked,
    input  logic            burst_only,
    input  logic [2:0]      mode,
    input  logic [3:0]      arb_pow,
    input  logic [CNTW-1:0] count_m1,
    input  logic [1:0]      src_size,
    input  logic [1:0]      dst_size,
    input  logic            sreq,
    input  logic            breq,
    input  logic [AW-1:0]   src_addr,
    input  logic [AW-1:0]   dst_addr,
    output logic [CNTW-1:0] items_left,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [1:0]      bus_size,
    output logic [DW-1:0]   bus_wdata,
    input  logic            bus_gnt,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_err,
    output logic            done_evt,
    output logic            err_evt,
    output logic            done_pulse
);
    import dma_chan_pkg::*;

    typedef struct packed {
        phase_e           ph;
        logic             armed;
        logic [CNTW-1:0]  left;
        logic [BEATW-1:0] beat;
        logic             single;
        logic [DW-1:0]    data;
        logic             done;
    } fsm_t;

    fsm_t s_d, s_q;
    logic             runnable;
    logic [BEATW-1:0] tenure_last;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        done_evt    = 1'b0;
        err_evt     = 1'b0;
        runnable    = glob_en && chan_en && !masked && (mode == MODE_BASIC);
        tenure_last = (BEATW'(1) << arb_pow) - BEATW'(1);
        unique case (s_q.ph)
            PH_IDLE: begin
                if (!chan_en) begin
                    s_d.armed = 1'b0;
                end else if (runnable) begin
                    if (!s_q.armed) begin
                        s_d.armed = 1'b1;
                        s_d.left  = count_m1;
                    end else if (breq) begin
                        s_d.ph     = PH_READ;
                        s_d.beat   = '0;
                        s_d.single = 1'b0;
                    end else if (sreq && !burst_only) begin
                        s_d.ph     = PH_READ;
                        s_d.beat   = '0;
                        s_d.single = 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (bus_gnt) begin
                    if (bus_err) begin
                        err_evt   = 1'b1;
                        s_d.armed = 1'b0;
                        s_d.ph    = PH_IDLE;
                    end else begin
                        s_d.data = bus_rdata;
                        s_d.ph   = PH_WRITE;
                    end
                end
            end
            PH_WRITE: begin
                if (bus_gnt) begin
                    if (bus_err) begin
                        err_evt   = 1'b1;
                        s_d.armed = 1'b0;
                        s_d.ph    = PH_IDLE;
                    end else if (s_q.left == '0) begin
                        done_evt  = 1'b1;
                        s_d.done  = 1'b1;
                        s_d.armed = 1'b0;
                        s_d.ph    = PH_IDLE;
                    end else begin
                        s_d.left = s_q.left - CNTW'(1);
                        s_d.beat = s_q.beat + BEATW'(1);
                        if (s_q.single || (s_q.beat == tenure_last)) begin
                            s_d.ph = PH_IDLE;
                        end else begin
                            s_d.ph = PH_READ;
                        end
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign items_left = s_q.left;
    assign bus_req    = (s_q.ph != PH_IDLE);
    assign bus_we     = (s_q.ph == PH_WRITE);
    assign bus_addr   = bus_we ? dst_addr : src_addr;
    assign bus_size   = bus_we ? dst_size : src_size;
    assign bus_wdata  = s_q.data;
    assign done_pulse = s_q.done;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          per_sreq,
    input  logic          per_breq,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_err,
    output logic          done_pulse,
    output logic          irq
);
    import dma_chan_pkg::*;

    localparam int SIDES = 2;

    logic       glob_en_w, chan_en_w, masked_w, burst_only_w;
    logic       done_evt_w, err_evt_w;
    logic [1:0] iflags_w;
    ctrl_word_t ctrl_w;
    logic [AW-1:0]    src_end_w, dst_end_w;
    logic [CNT_W-1:0] left_w;

    logic [AW-1:0] end_sel [SIDES];
    logic [1:0]    inc_sel [SIDES];
    logic [AW-1:0] addr_sel[SIDES];

    assign end_sel[0] = src_end_w;
    assign end_sel[1] = dst_end_w;
    assign inc_sel[0] = ctrl_w.src_inc;
    assign inc_sel[1] = ctrl_w.dst_inc;

    dma_cfg_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .off        (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .done_evt   (done_evt_w),
        .err_evt    (err_evt_w),
        .glob_en    (glob_en_w),
        .chan_en    (chan_en_w),
        .masked     (masked_w),
        .burst_only (burst_only_w),
        .ctrl       (ctrl_w),
        .src_end    (src_end_w),
        .dst_end    (dst_end_w),
        .flags      (iflags_w),
        .irq        (irq)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_addr_gen #(.AW(AW), .CNTW(CNT_W)) u_agen (
            .end_ptr    (end_sel[g]),
            .inc_code   (inc_sel[g]),
            .items_left (left_w),
            .item_addr  (addr_sel[g])
        );
    end

    dma_xfer_fsm #(.AW(AW), .DW(DW), .CNTW(CNT_W), .BEATW(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .glob_en    (glob_en_w),
        .chan_en    (chan_en_w),
        .masked     (masked_w),
        .burst_only (burst_only_w),
        .mode       (ctrl_w.mode),
        .arb_pow    (ctrl_w.arb_pow),
        .count_m1   (ctrl_w.count_m1),
        .src_size   (ctrl_w.src_size),
        .dst_size   (ctrl_w.dst_size),
        .sreq       (per_sreq),
        .breq       (per_breq),
        .src_addr   (addr_sel[0]),
        .dst_addr   (addr_sel[1]),
        .items_left (left_w),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_gnt    (bus_gnt),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .done_evt   (done_evt_w),
        .err_evt    (err_evt_w),
        .done_pulse (done_pulse)
    );

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_gnt,
    input logic          bus_err,
    input logic          done_pulse,
    input logic          glob_en,
    input logic          chan_en,
    input logic          masked,
    input logic [2:0]    mode,
    input logic [1:0]    iflags
);

    // R7
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(glob_en && chan_en && !masked && (mode == 3'b001)));

    // R11
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8
    done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!chan_en && (mode == 3'b000) && iflags[0]));

    // R9
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_err) |=> (!bus_req && !chan_en && iflags[1]));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .bus_err    (bus_err),
    .done_pulse (done_pulse),
    .glob_en    (glob_en_w),
    .chan_en    (chan_en_w),
    .masked     (masked_w),
    .mode       (ctrl_w.mode),
    .iflags     (iflags_w)
);

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RD_MIX = 32'h5A5A_0000;
    localparam int LOGN = 64;

    typedef struct packed {
        logic [9:0] cnt;
        logic [1:0] si;
        logic [1:0] di;
        logic [1:0] sz;
        logic [3:0] arb;
        logic       burst;
        logic [1:0] ws;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{10'd20, 2'd3, 2'd1, 2'd1, 4'd0, 1'b1, 2'd0},
        '{10'd7,  2'd2, 2'd2, 2'd2, 4'd2, 1'b1, 2'd1},
        '{10'd5,  2'd0, 2'd3, 2'd0, 4'd1, 1'b0, 2'd0},
        '{10'd0,  2'd1, 2'd1, 2'd1, 4'd3, 1'b1, 2'd2},
        '{10'd9,  2'd2, 2'd1, 2'd2, 4'd2, 1'b1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        per_sreq, per_breq;
    logic        bus_req, bus_we, bus_gnt, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        done_pulse, irq;

    int n_checks = 0;
    int n_errs   = 0;

    int          beat_n, seg_n, done_n, hold_err, wait_states, inj_err_beat;
    logic        log_we   [LOGN];
    logic [31:0] log_addr [LOGN];
    logic [31:0] log_data [LOGN];
    logic [1:0]  log_size [LOGN];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_engine u_dma_chan_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .per_sreq(per_sreq), .per_breq(per_breq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .done_pulse(done_pulse), .irq(irq)
    );

    // Bus slave model and monitor: acts on falling edges only.
    initial begin
        logic        pending, prev_req;
        logic [31:0] held_addr;
        logic        held_we;
        int          waited;
        pending = 1'b0; prev_req = 1'b0; held_addr = '0; held_we = 1'b0; waited = 0;
        bus_gnt = 1'b0; bus_err = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (!prev_req) seg_n++;
                if (!pending) begin
                    pending = 1'b1; held_addr = bus_addr; held_we = bus_we; waited = 0;
                end else if (bus_addr != held_addr || bus_we != held_we) begin
                    hold_err++;
                end
                if (waited < wait_states) begin
                    waited++;
                    bus_gnt = 1'b0; bus_err = 1'b0;
                end else begin
                    bus_gnt   = 1'b1;
                    bus_err   = (beat_n == inj_err_beat);
                    bus_rdata = bus_addr ^ RD_MIX;
                    if (beat_n < LOGN) begin
                        log_we[beat_n]   = bus_we;
                        log_addr[beat_n] = bus_addr;
                        log_data[beat_n] = bus_wdata;
                        log_size[beat_n] = bus_size;
                    end
                    beat_n++;
                    pending = 1'b0;
                end
            end else begin
                bus_gnt = 1'b0; bus_err = 1'b0; pending = 1'b0;
            end
            prev_req = bus_req;
            if (done_pulse) done_n++;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic clear_log();
        beat_n = 0; seg_n = 0; done_n = 0; hold_err = 0;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [9:0] cnt, input logic [1:0] si,
            input logic [1:0] di, input logic [1:0] sz, input logic [3:0] arb, input logic [2:0] md);
        return {7'd0, di, sz, si, sz, cnt, arb, md};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] e, input logic [1:0] inc,
                                             input int left);
        if (inc == 2'b11) return e;
        return e - (32'(left) << inc);
    endfunction

    task automatic wait_done(input int limit);
        for (int k = 0; k < limit && done_n == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] s_end, d_end, rd;
        int n, segs_exp, lim, mism;
        s_end = 32'h1000_0100 + 32'(idx) * 32'h1000;
        d_end = 32'h2000_0400 + 32'(idx) * 32'h1000;
        n   = int'(v.cnt) + 1;
        lim = 1 << v.arb;
        segs_exp = v.burst ? (n + lim - 1) / lim : n;
        wait_states = int'(v.ws);
        cfg_write(3'd1, s_end);
        cfg_write(3'd2, d_end);
        cfg_write(3'd3, mk_ctrl(v.cnt, v.si, v.di, v.sz, v.arb, 3'b001));
        cfg_write(3'd0, 32'h1);
        clear_log();
        cfg_write(3'd4, 32'h3);
        per_breq = v.burst; per_sreq = !v.burst;
        wait_done(4000);
        per_breq = 1'b0; per_sreq = 1'b0;
        // R4: item count and read/write pairing
        check(beat_n == 2 * n, "R4", $sformatf("vec%0d beats", idx), 32'(beat_n), 32'(2 * n));
        mism = 0;
        for (int i = 0; i < n && 2 * i + 1 < LOGN; i++) begin
            logic [31:0] ea_s, ea_d;
            ea_s = exp_addr(s_end, v.si, n - 1 - i);
            ea_d = exp_addr(d_end, v.di, n - 1 - i);
            if (log_we[2*i] !== 1'b0 || log_addr[2*i] !== ea_s || log_size[2*i] !== v.sz ||
                log_we[2*i+1] !== 1'b1 || log_addr[2*i+1] !== ea_d || log_size[2*i+1] !== v.sz ||
                log_data[2*i+1] !== (ea_s ^ RD_MIX)) begin
                if (mism == 0)
                    $display("vec%0d item %0d: rd %0h/%0h wr %0h/%0h data %0h/%0h", idx, i,
                             log_addr[2*i], ea_s, log_addr[2*i+1], ea_d,
                             log_data[2*i+1], ea_s ^ RD_MIX);
                mism++;
            end
        end
        // R3: addresses, sizes and copied data
        check(mism == 0, "R3", $sformatf("vec%0d mismatched items", idx), 32'(mism), 32'd0);
        // R5 / R6: tenures
        check(seg_n == segs_exp, v.burst ? "R5" : "R6", $sformatf("vec%0d tenures", idx),
              32'(seg_n), 32'(segs_exp));
        // R11
        check(hold_err == 0, "R11", $sformatf("vec%0d beat changed while waiting", idx),
              32'(hold_err), 32'd0);
        // R8
        check(done_n == 1, "R8", $sformatf("vec%0d done pulses", idx), 32'(done_n), 32'd1);
        cfg_read(3'd3, rd);
        check(rd[2:0] == 3'b000, "R8", $sformatf("vec%0d mode after done", idx), 32'(rd[2:0]), 32'd0);
        cfg_read(3'd4, rd);
        check(rd[0] == 1'b0, "R8", $sformatf("vec%0d enable after done", idx), 32'(rd[0]), 32'd0);
        cfg_write(3'd5, 32'h3);
        wait_states = 0;
    endtask

    task automatic program_std(input logic [2:0] md);
        cfg_write(3'd1, 32'h3000_0010);
        cfg_write(3'd2, 32'h4000_0010);
        cfg_write(3'd3, mk_ctrl(10'd3, 2'd2, 2'd2, 2'd2, 4'd1, md));
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        per_sreq = 1'b0; per_breq = 1'b0;
        wait_states = 0; inj_err_beat = -1;
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(bus_req == 1'b0 && done_pulse == 1'b0 && irq == 1'b0, "R1", "outputs after reset",
              {29'd0, bus_req, done_pulse, irq}, 32'd0);
        cfg_read(3'd4, rd);
        check(rd == 32'h2, "R1", "status after reset", rd, 32'h2);
        cfg_read(3'd5, rd);
        check(rd == 32'h0, "R1", "flags after reset", rd, 32'h0);
        cfg_read(3'd3, rd);
        check(rd == 32'h0, "R1", "control after reset", rd, 32'h0);

        // R2: control word readback
        cfg_write(3'd3, 32'h01AB_CDEF);
        cfg_read(3'd3, rd);
        check(rd == 32'h01AB_CDEF, "R2", "control readback", rd, 32'h01AB_CDEF);

        // Vector table
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R10: flag, enable and clear
        cfg_write(3'd6, 32'h0);
        program_std(3'b001);
        clear_log();
        cfg_write(3'd4, 32'h1);
        per_breq = 1'b1;
        wait_done(200);
        per_breq = 1'b0;
        cfg_read(3'd5, rd);
        check(rd == 32'h1, "R10", "done flag set", rd, 32'h1);
        check(irq == 1'b0, "R10", "irq with enable off", 32'(irq), 32'd0);
        cfg_write(3'd6, 32'h1);
        #1;
        check(irq == 1'b1, "R10", "irq with enable on", 32'(irq), 32'd1);
        cfg_write(3'd5, 32'h1);
        cfg_read(3'd5, rd);
        check(rd == 32'h0 && irq == 1'b0, "R10", "flag cleared by write-one", {rd[30:0], irq}, 32'd0);
        cfg_write(3'd6, 32'h0);

        // R7: requests masked
        cfg_write(3'd4, 32'h10);
        program_std(3'b001);
        clear_log();
        cfg_write(3'd4, 32'h1);
        per_breq = 1'b1;
        repeat (20) @(negedge clk);
        check(beat_n == 0, "R7", "beats while masked", 32'(beat_n), 32'd0);
        cfg_write(3'd4, 32'h2);
        wait_done(200);
        per_breq = 1'b0;
        check(done_n == 1, "R7", "done after unmask", 32'(done_n), 32'd1);
        cfg_write(3'd5, 32'h3);

        // R7: global enable off
        cfg_write(3'd0, 32'h0);
        program_std(3'b001);
        clear_log();
        cfg_write(3'd4, 32'h1);
        per_breq = 1'b1;
        repeat (20) @(negedge clk);
        check(beat_n == 0, "R7", "beats with global enable off", 32'(beat_n), 32'd0);
        cfg_write(3'd0, 32'h1);
        wait_done(200);
        per_breq = 1'b0;
        check(done_n == 1, "R7", "done after global enable", 32'(done_n), 32'd1);
        cfg_write(3'd5, 32'h3);

        // R7: stopped mode never runs
        program_std(3'b000);
        clear_log();
        cfg_write(3'd4, 32'h1);
        per_breq = 1'b1;
        repeat (20) @(negedge clk);
        per_breq = 1'b0;
        check(beat_n == 0, "R7", "beats with mode 000", 32'(beat_n), 32'd0);
        cfg_write(3'd4, 32'h20);
        cfg_read(3'd4, rd);
        check(rd[0] == 1'b0, "R7", "channel disabled by command", 32'(rd[0]), 32'd0);

        // R6: burst-only ignores single requests
        cfg_write(3'd4, 32'h4);
        program_std(3'b001);
        clear_log();
        cfg_write(3'd4, 32'h1);
        per_sreq = 1'b1;
        repeat (20) @(negedge clk);
        check(beat_n == 0, "R6", "beats on single request in burst-only", 32'(beat_n), 32'd0);
        per_breq = 1'b1;
        wait_done(200);
        per_breq = 1'b0; per_sreq = 1'b0;
        check(done_n == 1 && beat_n == 8, "R6", "burst request served", 32'(beat_n), 32'd8);
        cfg_write(3'd4, 32'h8);
        cfg_write(3'd5, 32'h3);

        // R9: error response on fourth beat (write of item 1)
        program_std(3'b001);
        clear_log();
        inj_err_beat = 3;
        cfg_write(3'd4, 32'h1);
        per_breq = 1'b1;
        repeat (30) @(negedge clk);
        per_breq = 1'b0;
        inj_err_beat = -1;
        check(beat_n == 4, "R9", "beats up to error", 32'(beat_n), 32'd4);
        check(done_n == 0, "R9", "no done after error", 32'(done_n), 32'd0);
        cfg_read(3'd5, rd);
        check(rd == 32'h2, "R9", "error flag", rd, 32'h2);
        cfg_read(3'd4, rd);
        check(rd[0] == 1'b0, "R9", "enable cleared by error", 32'(rd[0]), 32'd0);
        cfg_write(3'd6, 32'h2);
        #1;
        check(irq == 1'b1, "R10", "irq from error flag", 32'(irq), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule